// File: doc/BRIEF.md
# Bank of Reloading Down-Counter Timers

The block holds three independent down-counting timer channels behind a small word-addressed register bus. Channels 0 and 1 are narrow (16 bits by default) and channel 2 is wide (32 bits by default). Each channel has four registers: a load value, the live count, a control word and an interrupt-clear location.

A channel that is enabled decrements once for every pulse of its chosen tick enable. It can use either the fast or the slow tick input. When a tick arrives while the count is already zero, the channel underflows. In periodic mode it then restarts from its load value. Otherwise it wraps to the all-ones maximum of its width. Every underflow sets a level interrupt for that channel. The interrupt stays set until software writes any value to the channel's clear location.

Clock generation is outside the block: both tick inputs are one-cycle pulses in the system clock domain. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `dtimer_bank`

## Requirements
- R1: After reset, every load, count and control register of every channel reads 0, and all three interrupts are low.
- R2: Channel bases are 0x00, 0x20 and 0x80. Within a channel, the word at offset 0x0 is load, 0x4 is count, 0x8 is control and 0xC is clear. A register is hit only when addr[1:0] is 0. Any other address reads 0, and writes to it change nothing. The clear location always reads 0.
- R3: A write to load stores wdata truncated to the channel width into both the load register and the count. Reads of load and count are zero-extended to 32 bits.
- R4: In the control word, bit 7 is enable, bit 6 is periodic mode and bit 3 is fast tick select. These three bits read back in place and all other bits read 0. A control value of 0 stops the channel.
- R5: An enabled channel with a non-zero count decrements by one on each pulse of its selected tick. Bit 3 set selects tick_fast and bit 3 clear selects tick_slow. The unselected tick has no effect, and a disabled channel holds its count.
- R6: A selected tick while enabled and at count 0 is an underflow. The count becomes the load value in periodic mode, or all ones of the channel width otherwise. The channel's irq goes high on the same clock edge.
- R7: irq stays high until a write of any value to the channel's clear location, which drops it at the next edge. If an underflow occurs in the same cycle as the clear write, irq stays high.
- R8: A load write in the same cycle as a selected tick sets the count to the written value, and that tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast | input | 1 | Fast tick enable pulse |
| tick_slow | input | 1 | Slow tick enable pulse |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 3 | Per-channel interrupt level, bit n for channel n |

## Verification
The bench goes after the underflow edge. A design that flags the interrupt when the count reaches zero, instead of on the following tick, raises irq one tick early. A design that ignores the mode bit reloads when it should wrap. The bench also targets a clear write colliding with an underflow, where a clear-first design loses the event, and a load write colliding with a tick, where a tick-first design leaves the count one too low. Truncation and zero-extension on the narrow channels are tested, along with the unselected tick and misaligned or unmapped addresses. A design that gets any of these wrong shows a different count or irq at the bus or the interrupt pins.

// File: rtl/dtimer_bank.sv
module dtimer_bank #(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_fast,
  input  logic        tick_slow,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [2:0]  irq
);
  localparam int NCH = 3;

  function automatic logic [3:0] base_nib(input int c);
    return (c == 0) ? 4'h0 : (c == 1) ? 4'h2 : 4'h8;
  endfunction

  logic [31:0] rd_ch [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int W = (c == NCH - 1) ? WIDE_W : NARROW_W;
    logic [W-1:0] load_q, cnt_q;
    logic en_q, per_q, fast_q, irq_q;
    logic [31:0] rd;

    wire sel    = (addr[7:4] == base_nib(c)) && (addr[1:0] == 2'b00);
    wire wr_load = wr_en && sel && (addr[3:2] == 2'd0);
    wire wr_ctrl = wr_en && sel && (addr[3:2] == 2'd2);
    wire wr_clr  = wr_en && sel && (addr[3:2] == 2'd3);
    wire tick    = en_q && (fast_q ? tick_fast : tick_slow);
    wire under   = tick && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        load_q <= '0;
        cnt_q  <= '0;
        en_q   <= 1'b0;
        per_q  <= 1'b0;
        fast_q <= 1'b0;
        irq_q  <= 1'b0;
      end else begin
        if (wr_load) begin
          load_q <= wdata[W-1:0];
          cnt_q  <= wdata[W-1:0];
        end else if (tick) begin
          cnt_q <= under ? (per_q ? load_q : '1) : cnt_q - W'(1);
        end
        if (wr_ctrl) begin
          en_q   <= wdata[7];
          per_q  <= wdata[6];
          fast_q <= wdata[3];
        end
        if (under) irq_q <= 1'b1;
        else if (wr_clr) irq_q <= 1'b0;
      end
    end

    always_comb begin
      case (addr[3:2])
        2'd0:    rd = 32'(load_q);
        2'd1:    rd = 32'(cnt_q);
        2'd2:    rd = {24'b0, en_q, per_q, 2'b00, fast_q, 3'b000};
        default: rd = '0;
      endcase
    end

    assign rd_ch[c] = sel ? rd : '0;
    assign irq[c]   = irq_q;
  end

  assign rdata = rd_ch[0] | rd_ch[1] | rd_ch[2];
endmodule

module dtimer_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_fast,
  input logic        tick_slow,
  input logic        wr_en,
  input logic [7:0]  addr,
  input logic [31:0] rdata,
  input logic [2:0]  irq
);
  for (genvar c = 0; c < 3; c++) begin : g_c
    localparam logic [7:0] CLR = (c == 0) ? 8'h0C : (c == 1) ? 8'h2C : 8'h8C;

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] && !(wr_en && addr == CLR) |=> irq[c]);

    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == CLR && !tick_fast && !tick_slow |=> !irq[c]);

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[c]) |-> $past(tick_fast || tick_slow));

    // R2
    clr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr == CLR |-> rdata == 32'h0);
  end

  // R2
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr[7:4] == 4'h4 |-> rdata == 32'h0);

  // R5
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_fast && !tick_slow && !wr_en |=> $stable(irq));
endmodule

bind dtimer_bank dtimer_bank_chk u_chk (.*);

// File: tb/tb_dtimer_bank.sv
module tb_dtimer_bank;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick_fast = 0, tick_slow = 0, wr_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [2:0] irq;

  dtimer_bank dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_load [3], m_cnt [3];
  logic [7:0]  m_ctrl [3];
  logic [2:0]  m_irq;

  function automatic logic [31:0] wmask(int c);
    return (c == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [7:0] base_of(int c);
    return (c == 0) ? 8'h00 : (c == 1) ? 8'h20 : 8'h80;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    for (int c = 0; c < 3; c++)
      if (a[7:4] == base_of(c)[7:4] && a[1:0] == 2'b00)
        case (a[3:2])
          2'd0: return m_load[c];
          2'd1: return m_cnt[c];
          2'd2: return {24'b0, m_ctrl[c]};
          default: return 32'h0;
        endcase
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 3; c++) begin
      m_load[c] = 0; m_cnt[c] = 0; m_ctrl[c] = 0;
    end
    m_irq = 0;
  endtask

  task automatic model_step(logic we, logic [7:0] a, logic [31:0] d, logic tf, logic ts);
    for (int c = 0; c < 3; c++) begin
      logic hit, tk, un;
      hit = we && a[7:4] == base_of(c)[7:4] && a[1:0] == 2'b00;
      tk  = m_ctrl[c][7] && (m_ctrl[c][3] ? tf : ts);
      un  = tk && m_cnt[c] == 0;
      if (hit && a[3:2] == 2'd3) m_irq[c] = 1'b0;
      if (un) m_irq[c] = 1'b1;
      if (tk) m_cnt[c] = un ? (m_ctrl[c][6] ? m_load[c] : wmask(c)) : m_cnt[c] - 1;
      if (hit && a[3:2] == 2'd0) begin
        m_load[c] = d & wmask(c);
        m_cnt[c]  = d & wmask(c);
      end
      if (hit && a[3:2] == 2'd2) m_ctrl[c] = d[7:0] & 8'hC8;
    end
  endtask

  task automatic step(string tag, logic we, logic [7:0] a, logic [31:0] d, logic tf, logic ts);
    @(negedge clk);
    check({tag, " irq(R7)"}, {29'b0, irq}, {29'b0, m_irq});
    wr_en = we; addr = a; wdata = d; tick_fast = tf; tick_slow = ts;
    #1;
    check({tag, " read(R2)"}, rdata, exp_read(a));
    model_step(we, a, d, tf, ts);
  endtask

  task automatic rd(string tag, logic [7:0] a);
    step(tag, 0, a, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    model_reset();
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset state on all registers
    for (int c = 0; c < 3; c++)
      for (int r = 0; r < 4; r++) rd("R1", base_of(c) + 8'(4*r));

    // R3 truncation and zero-extension
    step("R3", 1, 8'h00, 32'h0001_2345, 0, 0);
    rd("R3", 8'h04);
    step("R3", 1, 8'h80, 32'hDEAD_BEEF, 0, 0);
    rd("R3", 8'h84);
    // R4 control readback and mask
    step("R4", 1, 8'h08, 32'hFFFF_FFFF, 0, 0);
    rd("R4", 8'h08);
    step("R4", 1, 8'h08, 32'h0, 1, 1);
    rd("R4", 8'h04);
    // R2 unmapped and misaligned
    step("R2", 1, 8'h41, 32'h5555_5555, 0, 0);
    rd("R2", 8'h41);
    step("R2", 1, 8'h01, 32'h7, 0, 0);
    rd("R2", 8'h00);

    // R5 one-shot wrap on fast tick, slow tick ignored
    step("R5", 1, 8'h00, 32'd2, 0, 0);
    step("R5", 1, 8'h08, 32'h88, 0, 0);
    step("R5", 0, 8'h04, 0, 0, 1);
    step("R5", 0, 8'h04, 0, 1, 0);
    step("R5", 0, 8'h04, 0, 1, 0);
    rd("R6 at zero", 8'h04);
    step("R6 wrap", 0, 8'h04, 0, 1, 0);
    rd("R6 wrap", 8'h04);
    // R7 clear colliding with underflow keeps irq, then plain clear
    step("R7", 1, 8'h20, 32'd0, 0, 0);
    step("R7", 1, 8'h28, 32'hC0, 0, 0);
    step("R7", 1, 8'h2C, 32'h0, 0, 1);
    rd("R7", 8'h24);
    step("R7", 1, 8'h2C, 32'h1234, 0, 0);
    step("R7", 1, 8'h0C, 32'h0, 0, 0);
    rd("R7", 8'h0C);
    // R6 periodic reload
    step("R6", 1, 8'h20, 32'd1, 0, 0);
    step("R6", 0, 8'h24, 0, 0, 1);
    step("R6", 0, 8'h24, 0, 0, 1);
    step("R6", 0, 8'h24, 0, 0, 1);
    rd("R6 reload", 8'h24);
    // R8 load write colliding with tick
    step("R8", 1, 8'h20, 32'd9, 0, 1);
    rd("R8", 8'h24);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      int c, r;
      logic we;
      logic [7:0] a;
      logic [31:0] d;
      c = $urandom_range(2);
      r = $urandom_range(3);
      a = base_of(c) + 8'(4*r);
      if ($urandom_range(19) == 0) a = 8'h40 | 8'($urandom_range(15));
      we = ($urandom_range(7) == 0);
      d = $urandom;
      if (r == 0 && $urandom_range(3) != 0) d = $urandom_range(6);
      if (r == 2) d = {24'b0, 1'b1, d[6:0]};
      if ($urandom_range(15) == 0) d[7] = 0;
      step("R5 random", we, a, d, $urandom_range(2) == 0, $urandom_range(3) == 0);
    end
    step("final", 0, 8'h84, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule